// File: doc/BRIEF.md
# Fractional-N Synthesizer Register Calculator

This block turns a requested receive frequency, given as an unsigned integer in hertz, into the four register bytes that program a fractional-N synthesizer: an output-divider code, an integer-step byte and a 16-bit sigma-delta fraction split into a high and a low byte. First it adds a fixed intermediate-frequency offset. Then it picks one of eight divider bands, each half the frequency of the one before. Last, it divides the distance above the band floor by the band's step size.

A request is accepted with a one-cycle `start` pulse while the block is idle. The integer index and the fraction come out of a single restoring division. The division produces one quotient bit per clock, and `done` pulses for one cycle when the bytes are valid. If the frequency falls in no band, the block raises `outOfRange` with `done` and clears every byte.

Top module: `pll_reg_calc`

## Requirements
- R1: The working frequency is the requested frequency plus 3,570,000 Hz, computed without overflow for any 32-bit request.
- R2: Band k (k = 0..7) spans 864,000,000>>k Hz to 1,785,600,000>>k Hz. The block picks the lowest-numbered band whose floor is strictly below and whose ceiling is strictly above the working frequency.
- R3: `divCode` holds the band number in bits 7:5 and zero in bits 4:0, giving 0x00, 0x20, ... 0xE0.
- R4: The band step is 28,800,000>>k Hz. The integer index is floor((working − floor) / step) and lies in 0..31.
- R5: `intByte` encodes the index with n = index+1 as follows: bits 7:6 = n mod 4, bits 5:4 = 0 and bits 3:0 = 4 + (n>>2). Index 0 gives 0x44 and index 31 gives 0x0C.
- R6: The fraction is floor(residual × 65536 / step), where residual = (working − floor) − index × step. `fracHi` carries fraction bits 15:8 and `fracLo` carries bits 7:0.
- R7: When no band contains the working frequency, `outOfRange` is 1 in the cycle `done` is 1, and all four bytes are zero.
- R8: `done` is high for exactly one cycle per accepted request. `busy` is high from the cycle after `start` is accepted until `done`. The outputs hold their values until the next request completes.
- R9: A `start` pulse while `busy` is high is ignored, and the running request completes with its own result.
- R10: Bands 6 and 7 are selected and encoded like any other band.
- R11: After reset `done`, `busy` and `outOfRange` are 0 and all four bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted when idle |
| freqHz | input | 32 | Requested frequency in hertz |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| outOfRange | output | 1 | No band contains the working frequency |
| divCode | output | 8 | Divider band code |
| intByte | output | 8 | Encoded integer-step byte |
| fracHi | output | 8 | Fraction high byte |
| fracLo | output | 8 | Fraction low byte |

## Verification
The conversion is tried with the worked request of 452,345,000 Hz, with requests that land exactly on a band floor (where two bands overlap), with the top edge of band 0 that yields index 31 and fraction 0xFFFF, and with low requests that fall into bands 6 and 7. A mid-range sweep covers every band and separates an error in band choice from an error in the index or the fraction. Requests just below the lowest band and exactly at the highest ceiling tell the strict bound tests apart from inclusive ones and confirm that the bytes clear. A second `start` during a calculation, and a check of `done` on the following cycle, separate a correctly ignored request and a single pulse from a restarted calculation.

// File: rtl/pllcalc_pkg.sv
package pllcalc_pkg;
  localparam int FREQ_W   = 32;
  localparam int WORK_W   = FREQ_W + 1;
  localparam int NUM_BANDS_DEF = 8;
  localparam int BAND_W   = 3;
  localparam int INT_W    = 5;
  localparam int FRAC_W   = 16;
  localparam int QUO_W    = INT_W + FRAC_W;
  localparam int OFF_W    = 30;
  localparam int REM_W    = OFF_W - INT_W;
  localparam int STEP_W   = REM_W;

  localparam logic [FREQ_W-1:0] IF_HZ_DEF   = 32'd3_570_000;
  localparam logic [FREQ_W-1:0] MIN_HZ_DEF  = 32'd864_000_000;
  localparam logic [FREQ_W-1:0] MAX_HZ_DEF  = 32'd1_785_600_000;
  localparam logic [FREQ_W-1:0] STEP_HZ_DEF = 32'd28_800_000;

  typedef struct packed {
    logic load;
    logic init;
    logic step;
    logic finish;
    logic reject;
  } strobes_t;

  function automatic logic [7:0] encodeIndex(input logic [INT_W-1:0] idx);
    logic [INT_W:0] n;
    n = {1'b0, idx} + 1'b1;
    return {n[1:0], 2'b00, 4'(4 + (n >> 2))};
  endfunction
endpackage

// File: rtl/pllcalc_ctrl.sv
module pllcalc_ctrl
  import pllcalc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     inRange,
  output strobes_t stb,
  output logic     busy,
  output logic     done
);
  localparam int CNT_W = $clog2(QUO_W);

  typedef enum logic [1:0] {S_IDLE, S_SEL, S_DIV, S_FIN} state_t;
  state_t state;
  logic [CNT_W-1:0] bitCnt;

  always_comb begin
    stb        = '0;
    stb.load   = (state == S_IDLE) && start;
    stb.init   = (state == S_SEL) && inRange;
    stb.reject = (state == S_SEL) && !inRange;
    stb.step   = (state == S_DIV);
    stb.finish = (state == S_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= stb.finish | stb.reject;
      unique case (state)
        S_IDLE: if (start) state <= S_SEL;
        S_SEL: begin
          bitCnt <= '0;
          state  <= inRange ? S_DIV : S_IDLE;
        end
        S_DIV: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == CNT_W'(QUO_W - 1)) state <= S_FIN;
        end
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);

  // R8: the result strobe is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8: when the result is flagged the block has returned to idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R9: while a request runs the state never falls back without a result
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DIV) |=> (state == S_DIV) || (state == S_FIN));
endmodule

// File: rtl/pllcalc_datapath.sv
module pllcalc_datapath
  import pllcalc_pkg::*;
#(
  parameter int                NUM_BANDS = NUM_BANDS_DEF,
  parameter logic [FREQ_W-1:0] IF_HZ     = IF_HZ_DEF,
  parameter logic [FREQ_W-1:0] MIN_HZ    = MIN_HZ_DEF,
  parameter logic [FREQ_W-1:0] MAX_HZ    = MAX_HZ_DEF,
  parameter logic [FREQ_W-1:0] STEP_HZ   = STEP_HZ_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [FREQ_W-1:0] freqHz,
  output logic              inRange,
  output logic              outOfRange,
  output logic [7:0]        divCode,
  output logic [7:0]        intByte,
  output logic [7:0]        fracHi,
  output logic [7:0]        fracLo
);
  logic [WORK_W-1:0] workQ;
  logic [BAND_W-1:0] bandSel, bandQ;
  logic [FREQ_W-1:0] bandMin;
  logic [OFF_W-1:0]  offset;
  logic [STEP_W-1:0] stepQ;
  logic [REM_W-1:0]  remQ;
  logic [QUO_W-1:0]  shQ, quoQ;
  logic [REM_W:0]    trial;

  // Band choice: scan from the top so the lowest matching band wins.
  always_comb begin
    inRange = 1'b0;
    bandSel = '0;
    for (int k = NUM_BANDS - 1; k >= 0; k--) begin
      if ((workQ > WORK_W'(MIN_HZ >> k)) && (workQ < WORK_W'(MAX_HZ >> k))) begin
        inRange = 1'b1;
        bandSel = BAND_W'(k);
      end
    end
  end

  assign bandMin = MIN_HZ >> bandSel;
  assign offset  = OFF_W'(workQ - WORK_W'(bandMin));
  assign trial   = {remQ, shQ[QUO_W-1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workQ <= '0;
      bandQ <= '0;
      stepQ <= '0;
      remQ  <= '0;
      shQ   <= '0;
      quoQ  <= '0;
    end else begin
      if (stb.load) workQ <= WORK_W'(freqHz) + WORK_W'(IF_HZ);
      if (stb.init) begin
        bandQ <= bandSel;
        stepQ <= STEP_W'(STEP_HZ >> bandSel);
        remQ  <= offset[OFF_W-1:INT_W];
        shQ   <= {offset[INT_W-1:0], {FRAC_W{1'b0}}};
        quoQ  <= '0;
      end
      if (stb.step) begin
        shQ <= shQ << 1;
        if (trial >= {1'b0, stepQ}) begin
          remQ <= REM_W'(trial - {1'b0, stepQ});
          quoQ <= {quoQ[QUO_W-2:0], 1'b1};
        end else begin
          remQ <= REM_W'(trial);
          quoQ <= {quoQ[QUO_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outOfRange <= 1'b0;
      divCode    <= '0;
      intByte    <= '0;
      fracHi     <= '0;
      fracLo     <= '0;
    end else if (stb.reject) begin
      outOfRange <= 1'b1;
      divCode    <= '0;
      intByte    <= '0;
      fracHi     <= '0;
      fracLo     <= '0;
    end else if (stb.finish) begin
      outOfRange <= 1'b0;
      divCode    <= {bandQ, 5'b0};
      intByte    <= encodeIndex(quoQ[QUO_W-1:FRAC_W]);
      fracHi     <= quoQ[FRAC_W-1:8];
      fracLo     <= quoQ[7:0];
    end
  end

  // R4: restoring invariant, the partial remainder stays below the step
  a_r4_rem_below_step: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |-> (remQ < REM_W'(stepQ)));
  // R2: the latched band really contains the working frequency
  a_r2_band_contains: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |-> (workQ > WORK_W'(MIN_HZ >> bandQ)) && (workQ < WORK_W'(MAX_HZ >> bandQ)));
  // R7: an out-of-range result carries all-zero bytes
  a_r7_oor_zero: assert property (@(posedge clk) disable iff (!rstN)
    outOfRange |-> (divCode == 8'h00) && (intByte == 8'h00) && (fracHi == 8'h00) && (fracLo == 8'h00));
  // R3: low five bits of the divider code are always clear
  a_r3_code_low_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(divCode != 8'h00) |-> (divCode[4:0] == 5'd0));
  // R5: a written step byte has bits 5:4 clear and a nibble in 4..12
  a_r5_int_form: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.finish) |-> (intByte[5:4] == 2'b00) && (intByte[3:0] >= 4'd4) && (intByte[3:0] <= 4'd12));
endmodule

// File: rtl/pll_reg_calc.sv
module pll_reg_calc
  import pllcalc_pkg::*;
#(
  parameter int                NUM_BANDS = NUM_BANDS_DEF,
  parameter logic [FREQ_W-1:0] IF_HZ     = IF_HZ_DEF,
  parameter logic [FREQ_W-1:0] MIN_HZ    = MIN_HZ_DEF,
  parameter logic [FREQ_W-1:0] MAX_HZ    = MAX_HZ_DEF,
  parameter logic [FREQ_W-1:0] STEP_HZ   = STEP_HZ_DEF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] freqHz,
  output logic        busy,
  output logic        done,
  output logic        outOfRange,
  output logic [7:0]  divCode,
  output logic [7:0]  intByte,
  output logic [7:0]  fracHi,
  output logic [7:0]  fracLo
);
  strobes_t stb;
  logic     inRange;

  pllcalc_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .inRange (inRange),
    .stb     (stb),
    .busy    (busy),
    .done    (done)
  );

  pllcalc_datapath #(
    .NUM_BANDS (NUM_BANDS),
    .IF_HZ     (IF_HZ),
    .MIN_HZ    (MIN_HZ),
    .MAX_HZ    (MAX_HZ),
    .STEP_HZ   (STEP_HZ)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .freqHz     (freqHz),
    .inRange    (inRange),
    .outOfRange (outOfRange),
    .divCode    (divCode),
    .intByte    (intByte),
    .fracHi     (fracHi),
    .fracLo     (fracLo)
  );
endmodule

// File: tb/sim_pll_reg_calc.sv
`timescale 1ns/1ps
module sim_pll_reg_calc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] freqHz = '0;
  logic        busy, done, outOfRange;
  logic [7:0]  divCode, intByte, fracHi, fracLo;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  pll_reg_calc u0 (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Reference built from the requirement text only
  task automatic model(input longint f, output bit oor, output logic [7:0] dc,
                       output logic [7:0] ib, output logic [15:0] fr);
    longint w, off, st, q, idx, n;
    int band;
    w = f + 64'd3570000;
    band = -1;
    for (int k = 7; k >= 0; k--)
      if (w > (64'd864000000 >> k) && w < (64'd1785600000 >> k)) band = k;
    oor = (band < 0);
    dc = 0; ib = 0; fr = 0;
    if (!oor) begin
      off = w - (64'd864000000 >> band);
      st  = 64'd28800000 >> band;
      q   = (off << 16) / st;
      idx = q >> 16;
      n   = idx + 1;
      dc  = 8'(band << 5);
      ib  = 8'(((n % 4) << 6) | (4 + (n >> 2)));
      fr  = 16'(q & 64'hFFFF);
    end
  endtask

  task automatic run_req(input logic [31:0] f, output bit gotDone);
    @(negedge clk); start = 1'b1; freqHz = f;
    @(negedge clk); start = 1'b0;
    gotDone = 1'b0;
    for (int i = 0; i < 60 && !gotDone; i++) begin
      if (done) gotDone = 1'b1; else @(negedge clk);
    end
  endtask

  task automatic check_req(input logic [31:0] f, input string tag);
    bit ok, oor;
    logic [7:0] dc, ib;
    logic [15:0] fr;
    model(f, oor, dc, ib, fr);
    run_req(f, ok);
    chk(ok, {tag, " done seen"}, ok, 1);
    chk(outOfRange == oor, {tag, " R7 flag"}, outOfRange, oor);
    chk(divCode == dc, {tag, " R2/R3 divCode"}, divCode, dc);
    chk(intByte == ib, {tag, " R4/R5 intByte"}, intByte, ib);
    chk({fracHi, fracLo} == fr, {tag, " R6 fraction"}, {fracHi, fracLo}, fr);
  endtask

  task automatic test_reset();
    chk(!done && !busy && !outOfRange, "R11 reset flags", {done, busy, outOfRange}, 0);
    chk({divCode, intByte, fracHi, fracLo} == 0, "R11 reset bytes",
        {divCode, intByte, fracHi, fracLo}, 0);
  endtask

  task automatic test_worked();
    bit ok;
    run_req(32'd452_345_000, ok);
    chk(divCode == 8'h20, "R1/R3 worked divCode", divCode, 8'h20);
    chk(intByte == 8'h84, "R5 worked intByte", intByte, 8'h84);
    chk(fracHi == 8'hA9, "R6 worked fracHi", fracHi, 8'hA9);
    chk(fracLo == 8'h27, "R6 worked fracLo", fracLo, 8'h27);
  endtask

  task automatic test_edges();
    bit ok;
    // working = 864e6 exactly: not inside band 0, lands in band 1 index 30
    run_req(32'd860_430_000, ok);
    chk(divCode == 8'h20 && intByte == 8'hCB && {fracHi, fracLo} == 0,
        "R2 overlap floor", {divCode, intByte, fracHi, fracLo}, 32'h20CB0000);
    // top of band 0: index 31, fraction all ones
    run_req(32'd1_782_029_999, ok);
    chk(divCode == 8'h00 && intByte == 8'h0C && {fracHi, fracLo} == 16'hFFFF,
        "R4/R5 top edge", {divCode, intByte, fracHi, fracLo}, 32'h000CFFFF);
  endtask

  task automatic test_low_bands();
    bit ok;
    run_req(32'd10_000_000, ok);
    chk(divCode == 8'hC0 && intByte == 8'h44 && {fracHi, fracLo} == 16'h27D2,
        "R10 band 6", {divCode, intByte, fracHi, fracLo}, 32'hC04427D2);
    run_req(32'd5_000_000, ok);
    chk(divCode == 8'hE0 && intByte == 8'h46 && {fracHi, fracLo} == 16'h16C1,
        "R10 band 7", {divCode, intByte, fracHi, fracLo}, 32'hE04616C1);
  endtask

  task automatic test_oor();
    check_req(32'd100_000_000, "pre-oor");
    check_req(32'd3_000_000, "R7 below");
    check_req(32'd1_782_030_000, "R7 ceiling");
    check_req(32'hFFFF_FFFF, "R1/R7 max input");
  endtask

  task automatic test_sweep();
    check_req(32'd1_200_000_000, "sweep b0");
    check_req(32'd700_000_000, "sweep b1");
    check_req(32'd300_000_000, "sweep b2");
    check_req(32'd150_000_000, "sweep b3");
    check_req(32'd88_500_000, "sweep b4");
    check_req(32'd40_000_000, "sweep b5");
    check_req(32'd15_000_000, "sweep b6");
    check_req(32'd7_777_777, "sweep b7");
  endtask

  task automatic test_busy_ignore();
    bit ok;
    @(negedge clk); start = 1'b1; freqHz = 32'd452_345_000;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy, "R8 busy during run", busy, 1);
    start = 1'b1; freqHz = 32'd5_000_000;
    @(negedge clk); start = 1'b0;
    ok = 1'b0;
    for (int i = 0; i < 60 && !ok; i++) begin
      if (done) ok = 1'b1; else @(negedge clk);
    end
    chk(ok && divCode == 8'h20 && intByte == 8'h84 && {fracHi, fracLo} == 16'hA927,
        "R9 start ignored", {divCode, intByte, fracHi, fracLo}, 32'h2084A927);
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
    chk(!busy, "R9 no second run", busy, 0);
    chk({divCode, intByte, fracHi, fracLo} == 32'h2084A927, "R8 outputs held",
        {divCode, intByte, fracHi, fracLo}, 32'h2084A927);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0x1 expected=0x0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_worked();
    test_edges();
    test_low_bands();
    test_oor();
    test_sweep();
    test_busy_ignore();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule